// File: doc/BRIEF.md
# Load Queue Snoop Invalidation Checker

When the memory system invalidates a cache block, loads that are already in flight may have read data that is now stale. This block takes one invalidation address at a time and walks the load queue from its oldest entry to its youngest. For each entry it decides whether that load must run again, whether it only needs a mark saying a snoop touched it, or whether nothing happens. The queue storage is outside the block. The block reads each entry's fields through flattened input vectors and returns its decisions as one update per cycle, naming the physical slot.

The oldest load is handled differently from the rest. For that entry the block only reports that a reservation made by a linked load has been lost. Younger loads that hit the block are sent back for re-execution if they already carry a possible-violation mark. Otherwise they receive a snoop-hit mark. In total-store-order mode, the first younger load that hits sends every later eligible load back for re-execution, even if that load does not hit. The walk takes one entry per clock. A busy output stays high for the whole walk, and while it is high new snoops are not accepted.

Top module: `lq_snoop_scan`

## Requirements
- R1: A load hits the snooped block if its first byte or its last byte lies in the same BLOCK_BYTES-aligned block as the snoop address. The last byte is base+size-1, taken modulo 2^ADDR_W, and a size of 0 counts as one byte. The low log2(BLOCK_BYTES) bits of the snoop address have no effect.
- R2: For the oldest entry (position 0 of the walk), upd_valid stays 0. lock_lost is 1 exactly when that entry has ent_addr_ok=1, hits the block, and has ent_linked=1.
- R3: A younger entry with ent_addr_ok=0 or ent_strict=1 produces neither an update nor lock_lost, and does not start forcing in total-store-order mode.
- R4: With tso_mode=0, a younger eligible entry that hits and has ent_pviol=1 produces an update with upd_reexec=1 and upd_snhit=0.
- R5: With tso_mode=0, a younger eligible entry that hits and has ent_pviol=0 produces an update with upd_snhit=1 and upd_reexec=0. lock_lost is also 1 when ent_linked=1.
- R6: With tso_mode=1, the first younger eligible entry that hits, and every younger eligible entry after it whether it hits or not, produces an update with upd_reexec=1 and lock_lost=0.
- R7: A snoop accepted while lq_count=0 never raises busy and produces no outputs.
- R8: A snoop is accepted on a rising edge where snoop_valid=1 and busy=0. With lq_count=C>0, busy is high for the next C cycles. In cycle k of those cycles (k=0..C-1) the outputs describe slot (lq_head+k) mod ENTRIES, and upd_idx carries that slot. Outside the walk, upd_valid and lock_lost are 0.
- R9: A snoop presented while busy=1 is not accepted and does not change the walk in progress. The block address, mode and queue bounds captured at acceptance are the ones used.
- R10: After reset, busy, upd_valid and lock_lost are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snoop_valid | input | 1 | Invalidation request present |
| snoop_addr | input | ADDR_W | Invalidated byte address |
| tso_mode | input | 1 | Total-store-order ordering mode |
| busy | output | 1 | Walk in progress; snoops stalled |
| lq_head | input | log2(ENTRIES) | Slot of the oldest load |
| lq_count | input | log2(ENTRIES+1) | Number of loads in the queue |
| ent_addr_ok | input | ENTRIES | Per-slot address-known bit |
| ent_strict | input | ENTRIES | Per-slot strictly-ordered bit |
| ent_linked | input | ENTRIES | Per-slot linked-load bit |
| ent_pviol | input | ENTRIES | Per-slot possible-violation bit |
| ent_base | input | ENTRIES*ADDR_W | Per-slot load base address |
| ent_size | input | ENTRIES*SIZE_W | Per-slot load size in bytes |
| upd_valid | output | 1 | An update for slot upd_idx this cycle |
| upd_idx | output | log2(ENTRIES) | Slot being examined |
| upd_reexec | output | 1 | Mark the slot for re-execution |
| upd_snhit | output | 1 | Set the slot's snoop-hit mark |
| lock_lost | output | 1 | A linked load's reservation was lost |

## Verification
The bench sweeps every head slot and every occupancy from empty to full, in both ordering modes, with snoops aimed at three neighbouring blocks and random in-block offsets. The queue holds pseudo-random loads, some of which straddle a block boundary. The straddling loads separate first-byte hits from last-byte hits. The mix of eligibility, linked and possible-violation bits separates the head-only lock path, the skip path, the re-execute path and the snoop-hit path. Head positions near the top of the queue exercise wrap-around of the walk. In half of the runs a different snoop, with the other mode, is held on the input during the walk to show that it is stalled and does not leak into the captured state.

// File: rtl/lqsnp_pkg.sv
package lqsnp_pkg;

  typedef enum logic [0:0] {
    SCAN_IDLE = 1'b0,
    SCAN_RUN  = 1'b1
  } lqsnp_state_e;

  typedef struct packed {
    logic upd;
    logic reexec;
    logic snhit;
    logic lock_lost;
    logic force_set;
  } lqsnp_verdict_t;

endpackage

// File: rtl/lqsnp_entry_sel.sv
module lqsnp_entry_sel #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 16,
  parameter int SIZE_W  = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [IDX_W-1:0]          idx,
  input  logic [ENTRIES-1:0]        ent_addr_ok,
  input  logic [ENTRIES-1:0]        ent_strict,
  input  logic [ENTRIES-1:0]        ent_linked,
  input  logic [ENTRIES-1:0]        ent_pviol,
  input  logic [ENTRIES*ADDR_W-1:0] ent_base,
  input  logic [ENTRIES*SIZE_W-1:0] ent_size,
  output logic                      sel_addr_ok,
  output logic                      sel_strict,
  output logic                      sel_linked,
  output logic                      sel_pviol,
  output logic [ADDR_W-1:0]         sel_base,
  output logic [SIZE_W-1:0]         sel_size
);

  logic [ENTRIES-1:0] slot_hot;

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_dec
      assign slot_hot[g] = (idx == IDX_W'(g));
    end
  endgenerate

  always_comb begin
    sel_addr_ok = 1'b0;
    sel_strict  = 1'b0;
    sel_linked  = 1'b0;
    sel_pviol   = 1'b0;
    sel_base    = '0;
    sel_size    = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (slot_hot[i]) begin
        sel_addr_ok = ent_addr_ok[i];
        sel_strict  = ent_strict[i];
        sel_linked  = ent_linked[i];
        sel_pviol   = ent_pviol[i];
        sel_base    = ent_base[i*ADDR_W +: ADDR_W];
        sel_size    = ent_size[i*SIZE_W +: SIZE_W];
      end
    end
  end

endmodule

// File: rtl/lqsnp_block_match.sv
module lqsnp_block_match #(
  parameter int ADDR_W      = 16,
  parameter int SIZE_W      = 4,
  parameter int BLOCK_BYTES = 64,
  localparam int OFF_W      = $clog2(BLOCK_BYTES),
  localparam int BLK_W      = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [ADDR_W-1:0] ld_base,
  input  logic [SIZE_W-1:0] ld_size,
  output logic              first_hit,
  output logic              last_hit,
  output logic              hit
);

  function automatic logic [BLK_W-1:0] blk_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  function automatic logic [ADDR_W-1:0] last_byte(input logic [ADDR_W-1:0] b,
                                                  input logic [SIZE_W-1:0] s);
    if (s == '0) return b;
    return b + ADDR_W'(s) - ADDR_W'(1);
  endfunction

  logic [BLK_W-1:0] snp_blk;
  logic [ADDR_W-1:0] end_addr;

  assign snp_blk   = blk_of(snp_addr);
  assign end_addr  = last_byte(ld_base, ld_size);
  assign first_hit = (blk_of(ld_base) == snp_blk);
  assign last_hit  = (blk_of(end_addr) == snp_blk);
  assign hit       = first_hit | last_hit;

endmodule

// File: rtl/lqsnp_verdict.sv
module lqsnp_verdict
  import lqsnp_pkg::*;
(
  input  logic           is_head,
  input  logic           addr_ok,
  input  logic           strict,
  input  logic           linked,
  input  logic           pviol,
  input  logic           hit,
  input  logic           force_q,
  input  logic           tso,
  output lqsnp_verdict_t verdict
);

  logic eligible;
  logic hitting;
  logic head_lock;
  logic do_reexec;

  assign eligible  = !is_head && addr_ok && !strict;
  assign hitting   = eligible && (hit || force_q);
  assign head_lock = is_head && addr_ok && hit && linked;
  assign do_reexec = hitting && (pviol || force_q || tso);

  always_comb begin
    verdict.upd       = hitting;
    verdict.reexec    = do_reexec;
    verdict.snhit     = hitting && !do_reexec;
    verdict.lock_lost = head_lock || (hitting && !do_reexec && linked);
    verdict.force_set = hitting && tso;
  end

endmodule

// File: rtl/lqsnp_scan_ctrl.sv
module lqsnp_scan_ctrl
  import lqsnp_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 16,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              tso_mode,
  input  logic [IDX_W-1:0]  lq_head,
  input  logic [CNT_W-1:0]  lq_count,
  input  logic              force_set,
  output logic              busy,
  output logic [IDX_W-1:0]  cur_idx,
  output logic              is_head,
  output logic              last,
  output logic [ADDR_W-1:0] snp_addr,
  output logic              tso_q,
  output logic              force_q
);

  localparam logic [IDX_W:0] ENT_V = (IDX_W + 1)'(ENTRIES);

  function automatic logic [IDX_W-1:0] wrap_add(input logic [IDX_W-1:0] a,
                                                input logic [IDX_W-1:0] b);
    logic [IDX_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= ENT_V) s = s - ENT_V;
    return s[IDX_W-1:0];
  endfunction

  lqsnp_state_e       state_q;
  logic [IDX_W-1:0]   pos_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [IDX_W-1:0]   head_q;
  logic [ADDR_W-1:0]  snp_q;
  logic               tso_r;
  logic               force_r;
  logic               accept;

  assign busy     = (state_q == SCAN_RUN);
  assign accept   = snoop_valid && !busy;
  assign cur_idx  = wrap_add(head_q, pos_q);
  assign is_head  = (pos_q == '0);
  assign last     = (CNT_W'(pos_q) == cnt_q - CNT_W'(1));
  assign snp_addr = snp_q;
  assign tso_q    = tso_r;
  assign force_q  = force_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SCAN_IDLE;
      pos_q   <= '0;
      cnt_q   <= '0;
      head_q  <= '0;
      snp_q   <= '0;
      tso_r   <= 1'b0;
      force_r <= 1'b0;
    end else if (accept) begin
      if (lq_count != '0) begin
        state_q <= SCAN_RUN;
        pos_q   <= '0;
        cnt_q   <= lq_count;
        head_q  <= lq_head;
        snp_q   <= snoop_addr;
        tso_r   <= tso_mode;
        force_r <= 1'b0;
      end
    end else if (busy) begin
      if (last) begin
        state_q <= SCAN_IDLE;
        pos_q   <= '0;
        force_r <= 1'b0;
      end else begin
        pos_q <= pos_q + IDX_W'(1);
        if (force_set) force_r <= 1'b1;
      end
    end
  end

  AST_SCAN_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last |=> busy && (pos_q == IDX_W'($past(pos_q) + IDX_W'(1)))); // R8
  AST_SCAN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && last |=> !busy); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last |=> $stable(snp_q) && $stable(tso_r) && $stable(head_q)); // R9
  AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && snoop_valid && (lq_count == '0) |=> !busy); // R7
  AST_NO_FORCE_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !tso_r |-> !force_r); // R6
  AST_FORCE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last && force_r |=> force_r); // R6

endmodule

// File: rtl/lq_snoop_scan.sv
module lq_snoop_scan
  import lqsnp_pkg::*;
#(
  parameter int ENTRIES     = 8,
  parameter int ADDR_W      = 16,
  parameter int SIZE_W      = 4,
  parameter int BLOCK_BYTES = 64,
  localparam int IDX_W      = $clog2(ENTRIES),
  localparam int CNT_W      = $clog2(ENTRIES + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      snoop_valid,
  input  logic [ADDR_W-1:0]         snoop_addr,
  input  logic                      tso_mode,
  output logic                      busy,
  input  logic [IDX_W-1:0]          lq_head,
  input  logic [CNT_W-1:0]          lq_count,
  input  logic [ENTRIES-1:0]        ent_addr_ok,
  input  logic [ENTRIES-1:0]        ent_strict,
  input  logic [ENTRIES-1:0]        ent_linked,
  input  logic [ENTRIES-1:0]        ent_pviol,
  input  logic [ENTRIES*ADDR_W-1:0] ent_base,
  input  logic [ENTRIES*SIZE_W-1:0] ent_size,
  output logic                      upd_valid,
  output logic [IDX_W-1:0]          upd_idx,
  output logic                      upd_reexec,
  output logic                      upd_snhit,
  output logic                      lock_lost
);

  logic              scan_busy;
  logic [IDX_W-1:0]  cur_idx;
  logic              is_head;
  logic              last;
  logic [ADDR_W-1:0] snp_addr;
  logic              tso_q;
  logic              force_q;

  logic              sel_addr_ok;
  logic              sel_strict;
  logic              sel_linked;
  logic              sel_pviol;
  logic [ADDR_W-1:0] sel_base;
  logic [SIZE_W-1:0] sel_size;

  logic              first_hit;
  logic              last_hit;
  logic              blk_hit;

  lqsnp_verdict_t    verdict;

  lqsnp_scan_ctrl #(
    .ENTRIES(ENTRIES),
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .snoop_valid(snoop_valid),
    .snoop_addr (snoop_addr),
    .tso_mode   (tso_mode),
    .lq_head    (lq_head),
    .lq_count   (lq_count),
    .force_set  (verdict.force_set),
    .busy       (scan_busy),
    .cur_idx    (cur_idx),
    .is_head    (is_head),
    .last       (last),
    .snp_addr   (snp_addr),
    .tso_q      (tso_q),
    .force_q    (force_q)
  );

  lqsnp_entry_sel #(
    .ENTRIES(ENTRIES),
    .ADDR_W (ADDR_W),
    .SIZE_W (SIZE_W)
  ) u_sel (
    .idx        (cur_idx),
    .ent_addr_ok(ent_addr_ok),
    .ent_strict (ent_strict),
    .ent_linked (ent_linked),
    .ent_pviol  (ent_pviol),
    .ent_base   (ent_base),
    .ent_size   (ent_size),
    .sel_addr_ok(sel_addr_ok),
    .sel_strict (sel_strict),
    .sel_linked (sel_linked),
    .sel_pviol  (sel_pviol),
    .sel_base   (sel_base),
    .sel_size   (sel_size)
  );

  lqsnp_block_match #(
    .ADDR_W     (ADDR_W),
    .SIZE_W     (SIZE_W),
    .BLOCK_BYTES(BLOCK_BYTES)
  ) u_match (
    .snp_addr (snp_addr),
    .ld_base  (sel_base),
    .ld_size  (sel_size),
    .first_hit(first_hit),
    .last_hit (last_hit),
    .hit      (blk_hit)
  );

  lqsnp_verdict u_verdict (
    .is_head(is_head),
    .addr_ok(sel_addr_ok),
    .strict (sel_strict),
    .linked (sel_linked),
    .pviol  (sel_pviol),
    .hit    (blk_hit),
    .force_q(force_q),
    .tso    (tso_q),
    .verdict(verdict)
  );

  assign busy       = scan_busy;
  assign upd_idx    = cur_idx;
  assign upd_valid  = scan_busy && verdict.upd;
  assign upd_reexec = scan_busy && verdict.reexec;
  assign upd_snhit  = scan_busy && verdict.snhit;
  assign lock_lost  = scan_busy && verdict.lock_lost;

  AST_HEAD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    busy && is_head |-> !upd_valid); // R2
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !upd_valid && !lock_lost); // R8
  AST_FORCED_REEXEC: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && force_q |-> upd_reexec && !lock_lost); // R6
  AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !is_head && (!sel_addr_ok || sel_strict) |-> !upd_valid && !lock_lost); // R3
  AST_UPD_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> $countones({upd_reexec, upd_snhit}) == 1); // R4
  AST_MISS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !first_hit && !last_hit && !force_q |-> !upd_valid && !lock_lost); // R1

endmodule

// File: tb/lq_snoop_scan_tb.sv
module lq_snoop_scan_tb;

  localparam int N  = 8;
  localparam int AW = 16;
  localparam int SW = 4;
  localparam int BB = 64;
  localparam int IW = $clog2(N);
  localparam int CW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic snoop_valid = 1'b0;
  logic [AW-1:0] snoop_addr = '0;
  logic tso_mode = 1'b0;
  logic busy;
  logic [IW-1:0] lq_head = '0;
  logic [CW-1:0] lq_count = '0;
  logic [N-1:0] ent_addr_ok = '0, ent_strict = '0, ent_linked = '0, ent_pviol = '0;
  logic [N*AW-1:0] ent_base;
  logic [N*SW-1:0] ent_size;
  logic upd_valid, upd_reexec, upd_snhit, lock_lost;
  logic [IW-1:0] upd_idx;

  int b_base [N];
  int b_size [N];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int unsigned seed = 32'h1234_5678;

  always #5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      ent_base[i*AW +: AW] = AW'(b_base[i]);
      ent_size[i*SW +: SW] = SW'(b_size[i]);
    end
  end

  lq_snoop_scan #(.ENTRIES(N), .ADDR_W(AW), .SIZE_W(SW), .BLOCK_BYTES(BB)) u_dut (
    .clk(clk), .rst_n(rst_n), .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .tso_mode(tso_mode), .busy(busy), .lq_head(lq_head), .lq_count(lq_count),
    .ent_addr_ok(ent_addr_ok), .ent_strict(ent_strict), .ent_linked(ent_linked),
    .ent_pviol(ent_pviol), .ent_base(ent_base), .ent_size(ent_size),
    .upd_valid(upd_valid), .upd_idx(upd_idx), .upd_reexec(upd_reexec),
    .upd_snhit(upd_snhit), .lock_lost(lock_lost)
  );

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // R1: block hit by first or last byte, size 0 counts as one byte
  function automatic bit hits(input int base, input int sz, input int a);
    int se;
    int lastb;
    se = (sz == 0) ? 1 : sz;
    lastb = (base + se - 1) % 65536;
    return (base / BB == a / BB) || (lastb / BB == a / BB);
  endfunction

  task automatic fill();
    for (int i = 0; i < N; i++) begin
      int unsigned r;
      r = rnd();
      b_base[i] = 256 + int'((r >> 2) % 4) * BB + int'((r >> 5) % 64);
      b_size[i] = int'((r >> 11) % 9);
      ent_addr_ok[i] = ((r >> 15) % 5) != 0;
      ent_strict[i]  = ((r >> 18) % 6) == 0;
      ent_linked[i]  = ((r >> 20) % 3) == 0;
      ent_pviol[i]   = ((r >> 22) % 3) == 0;
    end
  endtask

  task automatic run(input int head, input int cnt, input int v, input bit tso, input bit intr);
    int snp;
    bit frc;
    fill();
    snp = 256 + v * BB + int'(rnd() % 64);
    @(negedge clk);
    lq_head = IW'(head);
    lq_count = CW'(cnt);
    snoop_addr = AW'(snp);
    tso_mode = tso;
    snoop_valid = 1'b1;
    frc = 1'b0;
    if (cnt == 0) begin
      @(negedge clk);
      snoop_valid = 1'b0;
      chk("R7", "busy empty", int'(busy), 0);
      chk("R7", "upd empty", int'(upd_valid), 0);
      chk("R7", "lock empty", int'(lock_lost), 0);
      @(negedge clk);
      chk("R7", "busy empty later", int'(busy), 0);
      return;
    end
    for (int p = 0; p < cnt; p++) begin
      int idx;
      bit h, e_upd, e_re, e_sh, e_ll;
      string tag;
      @(negedge clk);
      idx = (head + p) % N;
      h = hits(b_base[idx], b_size[idx], snp);
      e_upd = 0; e_re = 0; e_sh = 0; e_ll = 0;
      if (p == 0) begin
        tag = "R2";
        e_ll = ent_addr_ok[idx] && h && ent_linked[idx];
      end else if (!ent_addr_ok[idx] || ent_strict[idx]) begin
        tag = "R3";
      end else if (h || frc) begin
        e_upd = 1;
        if (tso) begin
          tag = "R6"; e_re = 1; frc = 1;
        end else if (ent_pviol[idx]) begin
          tag = "R4"; e_re = 1;
        end else begin
          tag = "R5"; e_sh = 1; e_ll = ent_linked[idx];
        end
      end else begin
        tag = "R1";
      end
      chk("R8", $sformatf("busy pos %0d", p), int'(busy), 1);
      chk(tag, $sformatf("upd_valid slot %0d", idx), int'(upd_valid), int'(e_upd));
      chk(tag, $sformatf("reexec slot %0d", idx), int'(upd_reexec), int'(e_re));
      chk(tag, $sformatf("snhit slot %0d", idx), int'(upd_snhit), int'(e_sh));
      chk(tag, $sformatf("lock_lost slot %0d", idx), int'(lock_lost), int'(e_ll));
      if (e_upd) chk("R8", "upd_idx", int'(upd_idx), idx);
      if (p == cnt - 1) begin
        snoop_valid = 1'b0;
      end else if (p == 0) begin
        snoop_valid = intr;
        snoop_addr = AW'(snp ^ 16'h0040);
        tso_mode = ~tso;
      end
    end
    @(negedge clk);
    chk(intr ? "R9" : "R8", "busy after walk", int'(busy), 0);
    chk("R8", "upd after walk", int'(upd_valid), 0);
    chk("R8", "lock after walk", int'(lock_lost), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      b_base[i] = 0;
      b_size[i] = 0;
    end
    snoop_valid = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10", "busy in reset", int'(busy), 0);
    chk("R10", "upd in reset", int'(upd_valid), 0);
    chk("R10", "lock in reset", int'(lock_lost), 0);
    snoop_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "busy after reset", int'(busy), 0);
    for (int h = 0; h < N; h++)
      for (int c = 0; c <= N; c++)
        for (int t = 0; t < 2; t++)
          for (int v = 0; v < 3; v++)
            run(h, c, v, t[0], ((h + c + v) % 2) == 1);
    summary();
  end

endmodule